// File: doc/BRIEF.md
# Overlay Window Layer Arbiter

This block sits in a display scan path and decides, for every pixel, which of three layers owns it. The three layers are one full-screen base layer and two rectangular overlay windows. It takes the raster coordinate of the pixel being scanned and the geometry of the two overlays. It returns a layer code and a coordinate relative to the chosen layer's origin. A downstream fetch stage uses that coordinate to address the layer's image in memory. Scrolling inside an overlay is the fetch stage's task: it changes that window's memory start address. The window's screen placement does not change.

Overlay geometry is coarse horizontally and exact vertically. Start column and width count groups of 4 pixels. Start row and height count lines. Coordinates are measured from the top-left corner of the visible area. A vertical-flip mode turns both overlays off. The geometry and flip inputs are captured only on a frame-start pulse, so a window cannot change shape partway down the screen. One pixel is accepted per clock, and the result appears one clock later.

Top module: `pip_layer_sel`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the layer code is 0 and both relative coordinates are 0.
- R2: A pixel that no enabled overlay claims gets layer code 0 (base). Its relative x and y equal its raster x and y. The result is registered, so it appears one clock after the pixel is presented.
- R3: Overlay k (k = 1 or 2) claims pixel (x, y) when all of the following hold:
  - the overlay is enabled;
  - x >= start_col*4 and x < (start_col+width)*4;
  - y >= start_row and y < start_row+height.

  A claimed pixel gets layer code k. Its relative coordinate is (x - start_col*4, y - start_row).
- R4: Where both overlays claim a pixel, overlay 1 wins and the layer code is 1.
- R5: An overlay whose enable is low claims no pixel, whatever its geometry.
- R6: An overlay with width 0 or height 0 claims no pixel.
- R7: While the captured vertical-flip input is high, every pixel gets layer code 0 with its raster coordinate.
- R8: Geometry, enable and flip inputs take effect only through a frame-start pulse. The pixel presented in the same cycle as the pulse already uses the new values. Changes made without a pulse have no effect.
- R9: The layer code is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse with the first pixel of a frame; captures configuration |
| flip_en | input | 1 | Vertical-flip mode request; forces overlays off |
| pix_x | input | XW | Raster column |
| pix_y | input | YW | Raster row |
| ov1_en | input | 1 | Overlay 1 enable |
| ov1_col | input | XW-GX | Overlay 1 start column in 4-pixel units |
| ov1_row | input | YW | Overlay 1 start row |
| ov1_wid | input | XW-GX | Overlay 1 width in 4-pixel units |
| ov1_hgt | input | YW | Overlay 1 height in lines |
| ov2_en | input | 1 | Overlay 2 enable |
| ov2_col | input | XW-GX | Overlay 2 start column in 4-pixel units |
| ov2_row | input | YW | Overlay 2 start row |
| ov2_wid | input | XW-GX | Overlay 2 width in 4-pixel units |
| ov2_hgt | input | YW | Overlay 2 height in lines |
| layer | output | 2 | Owning layer: 0 base, 1 overlay 1, 2 overlay 2 |
| rel_x | output | XW | Column relative to the owning layer's origin |
| rel_y | output | YW | Row relative to the owning layer's origin |

## Verification
The bench probes each overlay edge on both sides: the first and last claimed column and row, and the first unclaimed one beyond each. This separates an off-by-one in the 4-pixel scaling from an inclusive/exclusive error.

Three cases use the same overlapping pair of windows:
- both windows enabled, which shows the priority;
- overlay 1 disabled, which shows that overlay 2 is drawn under it;
- flip requested, which shows that both overlays are suppressed.

Zero-size windows are placed where they would otherwise claim the probe pixel. A mid-frame geometry change is followed by a pulsed one, which separates capture on the pulse from capture that follows the live inputs.

// File: rtl/pip_pkg.sv
// Shared layer codes for the overlay layer arbiter.
package pip_pkg;
    typedef enum logic [1:0] {
        LAYER_BASE = 2'd0,
        LAYER_OV1  = 2'd1,
        LAYER_OV2  = 2'd2
    } layer_e;

    localparam int unsigned NUM_OV = 2;
endpackage

// File: rtl/pip_cfg_hold.sv
// Captures overlay geometry and flip mode on a frame-start pulse.
// Presents the configuration in force for the current pixel; the pulse cycle
// already sees the incoming values. Assumes frame_start is a one-cycle pulse.
// The effective enables already include the flip override.
module pip_cfg_hold #(
    parameter int unsigned NOV = 2,
    parameter int unsigned QW  = 9,
    parameter int unsigned YW  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    flip_in,
    input  logic [NOV-1:0]          en_in,
    input  logic [NOV-1:0][QW-1:0]  col_in,
    input  logic [NOV-1:0][QW-1:0]  wid_in,
    input  logic [NOV-1:0][YW-1:0]  row_in,
    input  logic [NOV-1:0][YW-1:0]  hgt_in,
    output logic                    flip_act,
    output logic [NOV-1:0]          en_act,
    output logic [NOV-1:0][QW-1:0]  col_act,
    output logic [NOV-1:0][QW-1:0]  wid_act,
    output logic [NOV-1:0][YW-1:0]  row_act,
    output logic [NOV-1:0][YW-1:0]  hgt_act
);
    logic                   flip_q;
    logic [NOV-1:0]         en_q;
    logic [NOV-1:0][QW-1:0] col_q, wid_q;
    logic [NOV-1:0][YW-1:0] row_q, hgt_q;

    // Hold the frame's configuration; reload only on the frame-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_q <= 1'b0;
            en_q   <= '0;
            col_q  <= '0;
            wid_q  <= '0;
            row_q  <= '0;
            hgt_q  <= '0;
        end else if (frame_start) begin
            flip_q <= flip_in;
            en_q   <= en_in;
            col_q  <= col_in;
            wid_q  <= wid_in;
            row_q  <= row_in;
            hgt_q  <= hgt_in;
        end
    end

    // Select the configuration in force for the pixel of this cycle.
    always_comb begin
        flip_act = frame_start ? flip_in : flip_q;
        col_act  = frame_start ? col_in  : col_q;
        wid_act  = frame_start ? wid_in  : wid_q;
        row_act  = frame_start ? row_in  : row_q;
        hgt_act  = frame_start ? hgt_in  : hgt_q;
        en_act   = (frame_start ? en_in : en_q) & {NOV{~flip_act}};
    end

    // R8: without a pulse the held configuration must not move
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(en_q) && $stable(col_q) && $stable(wid_q)
                          && $stable(row_q) && $stable(hgt_q) && $stable(flip_q)));
endmodule

// File: rtl/pip_win_hit.sv
// Tests one pixel against one rectangular overlay window.
// Horizontal geometry is in units of 2**GX pixels; vertical geometry is in lines.
// Bounds are computed one bit wider so a window reaching the right or bottom
// edge does not wrap. Also gives the pixel's offset from the window origin.
module pip_win_hit #(
    parameter int unsigned XW = 11,
    parameter int unsigned YW = 11,
    parameter int unsigned GX = 2,
    localparam int unsigned QW = XW - GX
) (
    input  logic          en,
    input  logic [QW-1:0] col,
    input  logic [QW-1:0] wid,
    input  logic [YW-1:0] row,
    input  logic [YW-1:0] hgt,
    input  logic [XW-1:0] px,
    input  logic [YW-1:0] py,
    output logic          hit,
    output logic [XW-1:0] rx,
    output logic [YW-1:0] ry
);
    logic [XW-1:0] lo_x;
    logic [QW:0]   end_q;
    logic [XW:0]   hi_x;
    logic [YW:0]   hi_y;
    logic          in_x, in_y;

    // Scale the window bounds to pixels and compare against the raster position.
    always_comb begin
        lo_x  = {col, {GX{1'b0}}};
        end_q = {1'b0, col} + {1'b0, wid};
        hi_x  = {end_q, {GX{1'b0}}};
        hi_y  = {1'b0, row} + {1'b0, hgt};
        in_x  = (px >= lo_x) && ({1'b0, px} < hi_x);
        in_y  = (py >= row) && ({1'b0, py} < hi_y);
        hit   = en && in_x && in_y;
        rx    = px - lo_x;
        ry    = py - row;
    end
endmodule

// File: rtl/pip_layer_sel.sv
// Per-pixel layer arbiter for a base layer and two overlay windows.
// Overlay 1 outranks overlay 2, and both outrank the base layer. The layer code
// and relative coordinate are registered, giving one clock of latency.
// Assumes one pixel per clock and frame_start pulsed with the first pixel.
module pip_layer_sel
    import pip_pkg::*;
#(
    parameter int unsigned XW = 11,
    parameter int unsigned YW = 11,
    parameter int unsigned GX = 2,
    localparam int unsigned QW = XW - GX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          flip_en,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic          ov1_en,
    input  logic [QW-1:0] ov1_col,
    input  logic [YW-1:0] ov1_row,
    input  logic [QW-1:0] ov1_wid,
    input  logic [YW-1:0] ov1_hgt,
    input  logic          ov2_en,
    input  logic [QW-1:0] ov2_col,
    input  logic [YW-1:0] ov2_row,
    input  logic [QW-1:0] ov2_wid,
    input  logic [YW-1:0] ov2_hgt,
    output logic [1:0]    layer,
    output logic [XW-1:0] rel_x,
    output logic [YW-1:0] rel_y
);
    logic                      flip_act;
    logic [NUM_OV-1:0]         en_act;
    logic [NUM_OV-1:0][QW-1:0] col_act, wid_act;
    logic [NUM_OV-1:0][YW-1:0] row_act, hgt_act;
    logic [NUM_OV-1:0]         hit;
    logic [NUM_OV-1:0][XW-1:0] wx;
    logic [NUM_OV-1:0][YW-1:0] wy;
    layer_e                    sel_layer;
    logic [XW-1:0]             sel_x;
    logic [YW-1:0]             sel_y;

    pip_cfg_hold #(.NOV(NUM_OV), .QW(QW), .YW(YW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .flip_in     (flip_en),
        .en_in       ({ov2_en, ov1_en}),
        .col_in      ({ov2_col, ov1_col}),
        .wid_in      ({ov2_wid, ov1_wid}),
        .row_in      ({ov2_row, ov1_row}),
        .hgt_in      ({ov2_hgt, ov1_hgt}),
        .flip_act    (flip_act),
        .en_act      (en_act),
        .col_act     (col_act),
        .wid_act     (wid_act),
        .row_act     (row_act),
        .hgt_act     (hgt_act)
    );

    for (genvar i = 0; i < NUM_OV; i++) begin : g_win
        pip_win_hit #(.XW(XW), .YW(YW), .GX(GX)) u_hit (
            .en  (en_act[i]),
            .col (col_act[i]),
            .wid (wid_act[i]),
            .row (row_act[i]),
            .hgt (hgt_act[i]),
            .px  (pix_x),
            .py  (pix_y),
            .hit (hit[i]),
            .rx  (wx[i]),
            .ry  (wy[i])
        );

        // R6: a zero-sized window must never report a hit
        a_r6_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
            (wid_act[i] == '0 || hgt_act[i] == '0) |-> !hit[i]);
    end

    // Fixed priority: overlay 1, then overlay 2, then the base layer.
    always_comb begin
        if (hit[0]) begin
            sel_layer = LAYER_OV1;
            sel_x     = wx[0];
            sel_y     = wy[0];
        end else if (hit[1]) begin
            sel_layer = LAYER_OV2;
            sel_x     = wx[1];
            sel_y     = wy[1];
        end else begin
            sel_layer = LAYER_BASE;
            sel_x     = pix_x;
            sel_y     = pix_y;
        end
    end

    // Register the decision for the fetch stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layer <= LAYER_BASE;
            rel_x <= '0;
            rel_y <= '0;
        end else begin
            layer <= sel_layer;
            rel_x <= sel_x;
            rel_y <= sel_y;
        end
    end

    // R9: code 3 is never produced
    a_r9_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        layer != 2'd3);
    // R4: an overlay-1 hit always wins the next output
    a_r4_ov1_first: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> layer == LAYER_OV1);
    // R7: flip mode forces the base layer
    a_r7_flip_base: assert property (@(posedge clk) disable iff (!rst_n)
        flip_act |=> layer == LAYER_BASE);
    // R2: unclaimed pixels pass the raster coordinate through
    a_r2_base_coord: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> (rel_x == $past(pix_x) && rel_y == $past(pix_y)));
endmodule

// File: tb/pip_layer_sel_tb.sv
// Directed bench for the overlay layer arbiter; one task per scenario.
module pip_layer_sel_tb;
    localparam int XW = 11;
    localparam int YW = 11;
    localparam int GX = 2;
    localparam int QW = XW - GX;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          flip_en = 1'b0;
    logic [XW-1:0] pix_x = '0;
    logic [YW-1:0] pix_y = '0;
    logic          ov1_en = 1'b0, ov2_en = 1'b0;
    logic [QW-1:0] ov1_col = '0, ov1_wid = '0, ov2_col = '0, ov2_wid = '0;
    logic [YW-1:0] ov1_row = '0, ov1_hgt = '0, ov2_row = '0, ov2_hgt = '0;
    logic [1:0]    layer;
    logic [XW-1:0] rel_x;
    logic [YW-1:0] rel_y;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pip_layer_sel #(.XW(XW), .YW(YW), .GX(GX)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .flip_en(flip_en),
        .pix_x(pix_x), .pix_y(pix_y),
        .ov1_en(ov1_en), .ov1_col(ov1_col), .ov1_row(ov1_row),
        .ov1_wid(ov1_wid), .ov1_hgt(ov1_hgt),
        .ov2_en(ov2_en), .ov2_col(ov2_col), .ov2_row(ov2_row),
        .ov2_wid(ov2_wid), .ov2_hgt(ov2_hgt),
        .layer(layer), .rel_x(rel_x), .rel_y(rel_y)
    );

    task automatic check(input string tag, input int el, input int ex, input int ey);
        n_run++;
        if (layer !== el[1:0] || rel_x !== ex[XW-1:0] || rel_y !== ey[YW-1:0]) begin
            n_fail++;
            $display("FAIL %s: actual layer=%0d x=%0d y=%0d expected layer=%0d x=%0d y=%0d",
                     tag, layer, rel_x, rel_y, el, ex, ey);
        end
    endtask

    // Present one pixel, then check the registered result after the next edge.
    task automatic px(input int x, input int y, input bit fs,
                      input int el, input int ex, input int ey, input string tag);
        @(negedge clk);
        pix_x = x[XW-1:0];
        pix_y = y[YW-1:0];
        frame_start = fs;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        check(tag, el, ex, ey);
    endtask

    task automatic set_ov1(input bit en, input int c, input int r, input int w, input int h);
        ov1_en = en; ov1_col = c[QW-1:0]; ov1_row = r[YW-1:0];
        ov1_wid = w[QW-1:0]; ov1_hgt = h[YW-1:0];
    endtask

    task automatic set_ov2(input bit en, input int c, input int r, input int w, input int h);
        ov2_en = en; ov2_col = c[QW-1:0]; ov2_row = r[YW-1:0];
        ov2_wid = w[QW-1:0]; ov2_hgt = h[YW-1:0];
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", 0, 0, 0);
    endtask

    task automatic t_base();
        set_ov1(0, 0, 0, 0, 0); set_ov2(0, 0, 0, 0, 0); flip_en = 1'b0;
        px(0, 0, 1, 0, 0, 0, "R2 origin");
        px(123, 45, 0, 0, 123, 45, "R2 interior");
        px(2047, 2047, 0, 0, 2047, 2047, "R2 far corner");
    endtask

    // Overlay 1 covers x 8..19, y 5..8.
    task automatic t_edges();
        set_ov1(1, 2, 5, 3, 4); set_ov2(0, 0, 0, 0, 0);
        px(0, 0, 1, 0, 0, 0, "R3 frame");
        px(8, 5, 0, 1, 0, 0, "R3 top-left");
        px(19, 8, 0, 1, 11, 3, "R3 bottom-right");
        px(20, 6, 0, 0, 20, 6, "R3 right edge excl");
        px(7, 6, 0, 0, 7, 6, "R3 left edge excl");
        px(10, 9, 0, 0, 10, 9, "R3 bottom edge excl");
        px(10, 4, 0, 0, 10, 4, "R3 top edge excl");
        // Overlay 2 alone: x 400..403, y 100..101.
        set_ov1(0, 0, 0, 0, 0); set_ov2(1, 100, 100, 1, 2);
        px(0, 0, 1, 0, 0, 0, "R3 frame ov2");
        px(403, 101, 0, 2, 3, 1, "R3 ov2 corner");
        // Window reaching the right edge: x 2044..2047.
        set_ov2(1, 511, 0, 1, 1);
        px(0, 1, 1, 0, 0, 1, "R3 frame edge");
        px(2047, 0, 0, 2, 3, 0, "R3 right screen edge");
    endtask

    // Overlay 1 x 8..23, overlay 2 x 16..31, both y 0..9.
    task automatic t_priority();
        set_ov1(1, 2, 0, 4, 10); set_ov2(1, 4, 0, 4, 10);
        px(0, 20, 1, 0, 0, 20, "R4 frame");
        px(16, 3, 0, 1, 8, 3, "R4 overlap ov1 wins");
        px(24, 3, 0, 2, 8, 3, "R4 ov2 only");
        px(10, 3, 0, 1, 2, 3, "R4 ov1 only");
    endtask

    task automatic t_disable();
        set_ov1(0, 2, 0, 4, 10); set_ov2(1, 4, 0, 4, 10);
        px(0, 20, 1, 0, 0, 20, "R5 frame");
        px(16, 3, 0, 2, 0, 3, "R5 disabled ov1 ignored");
        px(10, 3, 0, 0, 10, 3, "R5 disabled ov1 area base");
    endtask

    task automatic t_zero();
        set_ov1(1, 2, 0, 0, 10); set_ov2(1, 2, 0, 4, 0);
        px(0, 20, 1, 0, 0, 20, "R6 frame");
        px(8, 0, 0, 0, 8, 0, "R6 zero width and height");
        px(9, 5, 0, 0, 9, 5, "R6 zero size interior");
    endtask

    task automatic t_flip();
        set_ov1(1, 2, 0, 4, 10); set_ov2(1, 4, 0, 4, 10); flip_en = 1'b1;
        px(16, 3, 1, 0, 16, 3, "R7 flip on frame pixel");
        px(24, 3, 0, 0, 24, 3, "R7 flip ov2 area");
        flip_en = 1'b0;
        px(16, 4, 0, 0, 16, 4, "R7 flip held without pulse");
        px(16, 4, 1, 1, 8, 4, "R7 flip cleared on pulse");
    endtask

    // Overlay 1 x 8..19, y 5..8, then moved mid-frame to x 40..51.
    task automatic t_capture();
        flip_en = 1'b0;
        set_ov1(1, 2, 5, 3, 4); set_ov2(0, 0, 0, 0, 0);
        px(0, 0, 1, 0, 0, 0, "R8 frame A");
        set_ov1(1, 10, 5, 3, 4);
        px(8, 5, 0, 1, 0, 0, "R8 old window kept");
        px(40, 5, 0, 0, 40, 5, "R8 new window not yet");
        px(40, 5, 1, 1, 0, 0, "R8 pulse pixel uses new");
        px(8, 5, 0, 0, 8, 5, "R8 old window gone");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_base();
        t_edges();
        t_priority();
        t_disable();
        t_zero();
        t_flip();
        t_capture();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule